// File: doc/BRIEF.md
# Destination Address Hash Filter

This block decides, for each incoming Ethernet frame, whether to keep it, looking only at the 48-bit destination address. The six address bytes arrive one per valid cycle, first byte first, after a frame-start pulse. While they stream in, a CRC-32 is folded over them one byte per cycle. After the sixth byte the top bits of that CRC select one bit of a 64-bit multicast hash table. The address is also compared with the programmed station address and classified as broadcast, multicast or unicast.

Software programs the block through a simple word-write port. Two words set the station address, two words load the hash table, and one word holds four enable bits: accept everything, accept station match, accept hashed multicast and accept broadcast. One cycle after the sixth byte, the block raises a one-cycle result strobe. It also drives an accept flag and a 16-bit status word. Three bits of that word report which class of address was seen. The flags report the true comparison results even when the accept-everything mode admits the frame anyway.

Top module: `addr_hash_filter`

## Requirements
- R1: The CRC starts at all ones for each frame. Each byte is consumed least significant bit first. The feedback bit is CRC bit 31 XOR the data bit, with polynomial 0x04C11DB7 and no final inversion. Bits 31:26 of the CRC over the six bytes are the hash index, which selects table bit `index`.
- R2: A write with `reg_sel`=2 loads table bits 31:0 from `reg_wdata`. A write with `reg_sel`=3 loads table bits 63:32.
- R3: A write with `reg_sel`=0 loads address bytes 0..3, with byte 0 in `reg_wdata[7:0]`. A write with `reg_sel`=1 loads bytes 4 and 5 from `reg_wdata[15:0]`, with byte 4 in `reg_wdata[7:0]`. Byte 0 is the first byte on the wire.
- R4: A write with `reg_sel`=4 loads the mode bits from `reg_wdata[3:0]`: bit 0 accept all, bit 1 accept station match, bit 2 accept hashed multicast, bit 3 accept broadcast.
- R5: In `rx_status`, bit 13 flags broadcast, bit 14 flags station match and bit 15 flags multicast. All other bits read zero.
- R6: An all-ones destination is broadcast. Any other destination with bit 0 of byte 0 set is multicast. The station flag is set when all six bytes equal the station address.
- R7: `accept` is (all) OR (station-enable AND station match) OR (broadcast-enable AND broadcast) OR (multicast-enable AND multicast AND selected table bit set).
- R8: With accept-all set, every frame is accepted, and the three flags still show the true classification.
- R9: `result_valid` pulses for exactly one cycle, on the cycle after the sixth byte is taken. `accept` and the flags update on that same cycle. Bytes beyond the sixth are ignored until the next frame start.
- R10: `frame_start` restarts the CRC and the byte count, and on the next cycle `accept` and the flags read zero. A byte that is valid in the same cycle as `frame_start` counts as byte 0.
- R11: After reset, the station address, table and mode are zero, and `result_valid`, `accept` and `rx_status` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | SEL_W (3) | Register select: 0/1 station, 2/3 table, 4 mode |
| reg_wdata | input | REG_W (32) | Register write data |
| frame_start | input | 1 | Start-of-frame pulse |
| addr_valid | input | 1 | `addr_byte` holds a destination byte |
| addr_byte | input | 8 | Destination address byte, first byte first |
| result_valid | output | 1 | One-cycle strobe: decision ready |
| accept | output | 1 | Frame accepted |
| rx_status | output | 16 | Bit 15 multicast, bit 14 station match, bit 13 broadcast |

## Verification
The hardest case to reach from the ports is a multicast frame whose acceptance depends on one specific table bit. The bench computes the CRC hash index with its own bit-serial model. It then loads a table holding only that bit, then a table holding every bit except that one, and it places the bit through whichever word write covers it. The same is done for a second group address that hashes elsewhere. It also restarts a frame after three bytes and drives bytes past the sixth, to check that only a complete, fresh address produces a single result.

// File: rtl/addr_filt_pkg.sv
package addr_filt_pkg;

  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;

  // enable bits, bit 0 in the least significant position
  typedef struct packed {
    logic bcast_en;
    logic mcast_en;
    logic phys_en;
    logic all_en;
  } mode_t;

  typedef struct packed {
    logic mcast;
    logic phys;
    logic bcast;
  } match_t;

  // one byte of the CRC, data taken lsb first, no reflection of the register
  function automatic logic [31:0] crc_byte(input logic [31:0] c_in, input logic [7:0] d);
    logic [31:0] c;
    logic        fb;
    c = c_in;
    for (int b = 0; b < 8; b++) begin
      fb = c[31] ^ d[b];
      c  = {c[30:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

endpackage

// File: rtl/filt_regs.sv
module filt_regs
  import addr_filt_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int SEL_W  = 3,
  parameter int ADDR_W = 48,
  parameter int TBL_N  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [SEL_W-1:0]  sel,
  input  logic [REG_W-1:0]  wdata,
  output logic [ADDR_W-1:0] station,
  output logic [TBL_N-1:0]  table_q,
  output mode_t             mode
);
  localparam int TBL_WORDS = TBL_N / REG_W;
  localparam int TBL_BASE  = 2;
  localparam int MODE_SEL  = TBL_BASE + TBL_WORDS;
  localparam int HI_W      = ADDR_W - REG_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      station <= '0;
      mode    <= '0;
    end else if (we) begin
      if (sel == SEL_W'(0)) station[REG_W-1:0]      <= wdata;
      if (sel == SEL_W'(1)) station[ADDR_W-1:REG_W] <= wdata[HI_W-1:0];
      if (sel == SEL_W'(MODE_SEL)) mode <= mode_t'(wdata[3:0]);
    end
  end

  for (genvar w = 0; w < TBL_WORDS; w++) begin : g_tbl
    always_ff @(posedge clk) begin
      if (rst) table_q[w*REG_W +: REG_W] <= '0;
      else if (we && sel == SEL_W'(TBL_BASE + w)) table_q[w*REG_W +: REG_W] <= wdata;
    end
  end

  assert_tbl_lo_R2: assert property (@(posedge clk) disable iff (rst)
    (we && sel == SEL_W'(TBL_BASE)) |=> (table_q[REG_W-1:0] == $past(wdata)));

endmodule

// File: rtl/filt_capture.sv
module filt_capture
  import addr_filt_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic                    valid,
  input  logic [7:0]              din,
  output logic                    last,
  output logic [ADDR_BYTES*8-1:0] addr_full,
  output logic [HASH_BITS-1:0]    hash_idx
);
  localparam int ADDR_W = ADDR_BYTES * 8;
  localparam int CW     = $clog2(ADDR_BYTES + 1);

  logic [CW-1:0]     cnt_q, base_cnt;
  logic [31:0]       crc_q, base_crc, crc_d;
  logic [ADDR_W-1:0] addr_q;
  logic              take;

  always_comb begin
    base_cnt = start ? '0 : cnt_q;
    base_crc = start ? '1 : crc_q;
    take     = valid && (base_cnt < CW'(ADDR_BYTES));
    last     = take && (base_cnt == CW'(ADDR_BYTES - 1));
    crc_d    = crc_byte(base_crc, din);
    hash_idx = crc_d[31 -: HASH_BITS];
  end

  for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_byte
    assign addr_full[i*8 +: 8] = (base_cnt == CW'(i)) ? din : addr_q[i*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      crc_q  <= '1;
      addr_q <= '0;
    end else if (take) begin
      cnt_q  <= base_cnt + CW'(1);
      crc_q  <= crc_d;
      addr_q <= addr_full;
    end else if (start) begin
      cnt_q <= '0;
      crc_q <= '1;
    end
  end

  assert_start_clears_R10: assert property (@(posedge clk) disable iff (rst)
    (start && !valid) |=> (cnt_q == '0 && crc_q == '1));

endmodule

// File: rtl/filt_decide.sv
module filt_decide
  import addr_filt_pkg::*;
#(
  parameter int ADDR_W    = 48,
  parameter int HASH_BITS = 6,
  parameter int TBL_N     = 64
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [HASH_BITS-1:0] hash_idx,
  input  logic [ADDR_W-1:0]    station,
  input  logic [TBL_N-1:0]     table_q,
  input  mode_t                mode,
  output logic                 accept,
  output match_t               match
);
  logic hit;

  always_comb begin
    match.bcast = &addr;
    match.mcast = addr[0] && !match.bcast;
    match.phys  = (addr == station);
    hit         = table_q[hash_idx];
    accept = mode.all_en
          || (mode.phys_en  && match.phys)
          || (mode.bcast_en && match.bcast)
          || (mode.mcast_en && match.mcast && hit);
  end

endmodule

// File: rtl/addr_hash_filter.sv
module addr_hash_filter
  import addr_filt_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 6,
  parameter int REG_W      = 32,
  parameter int SEL_W      = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             frame_start,
  input  logic             addr_valid,
  input  logic [7:0]       addr_byte,
  output logic             result_valid,
  output logic             accept,
  output logic [15:0]      rx_status
);
  localparam int ADDR_W = ADDR_BYTES * 8;
  localparam int TBL_N  = 1 << HASH_BITS;

  logic [ADDR_W-1:0]    station, addr_full;
  logic [TBL_N-1:0]     table_q;
  mode_t                mode;
  logic                 last, acc_d;
  logic [HASH_BITS-1:0] hash_idx;
  match_t               match_d, match_q;

  filt_regs #(.REG_W(REG_W), .SEL_W(SEL_W), .ADDR_W(ADDR_W), .TBL_N(TBL_N)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .station(station), .table_q(table_q), .mode(mode));

  filt_capture #(.ADDR_BYTES(ADDR_BYTES), .HASH_BITS(HASH_BITS)) u_cap (
    .clk(clk), .rst(rst), .start(frame_start), .valid(addr_valid), .din(addr_byte),
    .last(last), .addr_full(addr_full), .hash_idx(hash_idx));

  filt_decide #(.ADDR_W(ADDR_W), .HASH_BITS(HASH_BITS), .TBL_N(TBL_N)) u_dec (
    .addr(addr_full), .hash_idx(hash_idx), .station(station), .table_q(table_q),
    .mode(mode), .accept(acc_d), .match(match_d));

  always_ff @(posedge clk) begin
    if (rst) begin
      result_valid <= 1'b0;
      accept       <= 1'b0;
      match_q      <= '0;
    end else begin
      result_valid <= last;
      if (last) begin
        accept  <= acc_d;
        match_q <= match_d;
      end else if (frame_start) begin
        accept  <= 1'b0;
        match_q <= '0;
      end
    end
  end

  assign rx_status = {match_q.mcast, match_q.phys, match_q.bcast, 13'd0};

  assert_valid_after_last_R9: assert property (@(posedge clk) disable iff (rst)
    last |=> result_valid);

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> !result_valid);

  assert_accept_on_result_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(accept) |-> result_valid);

  assert_start_clears_flags_R10: assert property (@(posedge clk) disable iff (rst)
    (frame_start && !last) |=> (rx_status == 16'd0 && !accept));

  assert_bcast_not_mcast_R6: assert property (@(posedge clk) disable iff (rst)
    !(rx_status[13] && rx_status[15]));

endmodule

// File: tb/addr_hash_filter_test.sv
module addr_hash_filter_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic        frame_start = 1'b0;
  logic        addr_valid = 1'b0;
  logic [7:0]  addr_byte = '0;
  logic        result_valid, accept;
  logic [15:0] rx_status;

  always #5 clk = ~clk;

  addr_hash_filter uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .frame_start(frame_start), .addr_valid(addr_valid), .addr_byte(addr_byte),
    .result_valid(result_valid), .accept(accept), .rx_status(rx_status));

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit done     = 0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          when;
    logic        acc;
    logic [15:0] st;
    string       tag;
  } exp_t;
  exp_t sb[$];

  // bench model of programmed state
  logic [47:0] m_station = '0;
  logic [63:0] m_table   = '0;
  logic [3:0]  m_mode    = '0;

  function automatic logic [5:0] hidx(input logic [47:0] a);
    logic [31:0] c;
    logic fb;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < 6; i++)
      for (int b = 0; b < 8; b++) begin
        fb = c[31] ^ a[8*i + b];
        c  = c << 1;
        if (fb) c = c ^ 32'h04C11DB7;
      end
    return c[31:26];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    case (s)
      3'd0: m_station[31:0]  = d;
      3'd1: m_station[47:32] = d[15:0];
      3'd2: m_table[31:0]    = d;
      3'd3: m_table[63:32]   = d;
      3'd4: m_mode           = d[3:0];
      default: ;
    endcase
  endtask

  task automatic set_table(input logic [63:0] t);
    wr(3'd2, t[31:0]);
    wr(3'd3, t[63:32]);
  endtask

  // byte i of a is a[8*i +: 8], byte 0 sent first
  task automatic send(input logic [47:0] a, input int extra, input bit start_alone, input string tag);
    exp_t e;
    logic bc, mc, ph, hit;
    bc = &a; mc = a[0] && !bc; ph = (a == m_station); hit = m_table[hidx(a)];
    e.acc = m_mode[0] || (m_mode[1] && ph) || (m_mode[3] && bc) || (m_mode[2] && mc && hit);
    e.st  = {mc, ph, bc, 13'd0};
    e.tag = tag;
    if (start_alone) begin
      @(negedge clk); frame_start = 1'b1; addr_valid = 1'b0;
    end
    for (int i = 0; i < 6 + extra; i++) begin
      @(negedge clk);
      frame_start = (i == 0) && !start_alone;
      addr_valid  = 1'b1;
      addr_byte   = (i < 6) ? a[8*i +: 8] : 8'hA5;
      if (i == 5) begin e.when = cyc + 1; sb.push_back(e); end
    end
    @(negedge clk);
    frame_start = 1'b0; addr_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && result_valid) begin
      if (sb.size() == 0) begin
        check("R9 unexpected result", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({"R9 timing ", e.tag}, 32'(cyc), 32'(e.when));
        check({"R7 accept ", e.tag}, 32'(accept), 32'(e.acc));
        check({"R5/R6 status ", e.tag}, 32'(rx_status), 32'(e.st));
      end
    end
  end

  localparam logic [47:0] STA   = 48'h5544_3322_1100;
  localparam logic [47:0] OTHER = 48'h5544_3322_1102;
  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] MC1   = 48'h0100_005E_0001;
  localparam logic [47:0] MC2   = 48'hFB00_005E_0001;

  initial begin
    logic [63:0] t;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check("R11 result_valid", 32'(result_valid), 0);
    check("R11 accept", 32'(accept), 0);
    check("R11 status", 32'(rx_status), 0);
    send(STA, 0, 0, "R11 zero mode rejects");

    // R3 station, R4 phys enable
    wr(3'd0, STA[31:0]);
    wr(3'd1, {16'hDEAD, STA[47:32]});
    wr(3'd4, 32'h2);
    send(STA, 0, 0, "R3 station match");
    send(OTHER, 0, 1, "R6 unicast miss");

    // broadcast
    send(BCAST, 0, 0, "R6 bcast disabled");
    wr(3'd4, 32'hA);
    send(BCAST, 0, 0, "R7 bcast enabled");

    // R10 flags hold, then cleared by frame_start
    repeat (3) @(negedge clk);
    check("R10 flags held", 32'(rx_status), 32'h2000);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    check("R10 status cleared", 32'(rx_status), 0);
    check("R10 accept cleared", 32'(accept), 0);

    // R1/R2 multicast hash
    wr(3'd4, 32'hE);
    send(MC1, 0, 0, "R1 empty table");
    t = 64'd1 << hidx(MC1);
    set_table(t);
    send(MC1, 0, 0, "R1 R2 single bit hit");
    set_table(~t);
    send(MC1, 0, 0, "R1 R2 all but hit");
    t = 64'd1 << hidx(MC2);
    set_table(t);
    send(MC2, 0, 1, "R1 second group address");
    send(MC1, 0, 0, "R1 other bit only");
    wr(3'd4, 32'hA);
    send(MC2, 0, 0, "R7 mcast disabled");

    // R8 accept-all
    wr(3'd4, 32'h1);
    send(OTHER, 0, 0, "R8 all unicast");
    send(STA, 0, 0, "R8 all station flag");
    send(MC2, 0, 0, "R8 all mcast flag");

    // R9 extra bytes ignored, R10 restart mid-address
    wr(3'd4, 32'h2);
    send(STA, 4, 0, "R9 extra bytes");
    @(negedge clk);
    frame_start = 1'b1; addr_valid = 1'b1; addr_byte = 8'hFF;
    @(negedge clk);
    frame_start = 1'b0; addr_byte = 8'hFF;
    @(negedge clk);
    addr_byte = 8'hFF;
    @(negedge clk);
    addr_valid = 1'b0;
    send(STA, 0, 0, "R10 restart");

    repeat (5) @(negedge clk);
    check("R9 all results seen", 32'(sb.size()), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule